// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Manager

This block keeps an asynchronous DRAM alive. After reset it waits out a start-up pause and then runs a burst of wake-up refresh cycles. Only then does it raise `init_done_o`, which tells the access sequencer that normal traffic may begin. From that point it raises a refresh request at a fixed interval. The default interval of 1560 clocks spreads 2048 refreshes over a 32 ms window at 100 MHz. Each request borrows the memory bus from the access sequencer through a request/grant pair. While it holds the bus, the block drives the strobes itself.

Each refresh cycle uses one of two forms, picked at its start by `mode_ro_i`:
- **CAS-before-RAS.** CAS is lowered first, then RAS. The address is ignored.
- **RAS-only.** CAS stays high and RAS is strobed while the address bus carries the row from an internal 11-bit row counter.

Write enable and output enable are held inactive (high) at all times, so the data bus is never driven. Refresh requests that cannot be served at once are counted in a backlog. If the backlog grows past its limit, the block:
- sets a sticky overrun flag,
- withdraws `init_done_o`,
- runs the wake-up burst again.

Top module: `dram_refresh_mgr`

## Requirements
- R1: From reset release the block holds RAS and CAS high and `req_o` low for exactly PAUSE_CYC clock edges; `req_o` rises after edge PAUSE_CYC, and `init_done_o` and `overrun_o` read 0 during reset.
- R2: `init_done_o` rises only after exactly WAKE_CNT refresh cycles have released RAS since the pause (or since the last overrun), on the same edge as the last of those RAS releases.
- R3: A CAS-before-RAS cycle (`mode_ro_i`=0 at its start) lowers CAS for LEAD_CYC clocks with RAS high, then holds both low for RAS_CYC clocks, then raises both together. Both stay high for at least PRE_CYC clocks before any strobe falls again, and `addr_o` is 0 while they are low.
- R4: A RAS-only cycle (`mode_ro_i`=1 at its start) keeps CAS high. It presents the row on `addr_o` for LEAD_CYC clocks before RAS falls, holds it while RAS is low for RAS_CYC clocks, and obeys the same PRE_CYC precharge.
- R5: The row counter starts at 0 after reset, advances by one after each RAS-only cycle, and wraps from 2047 to 0. CAS-before-RAS cycles do not move it.
- R6: `we_n_o` and `oe_n_o` are 1 in every cycle.
- R7: A refresh cycle starts only on an edge where `req_o` and `grant_i` are both 1. Once started, it runs to the end of precharge whatever `grant_i` does.
- R8: The cycle form is taken from `mode_ro_i` at the edge where the cycle starts. Later changes of `mode_ro_i` do not affect that cycle.
- R9: After `init_done_o` rises at edge D, a refresh request is counted at edges D+k·INTERVAL_CYC for k≥1. With the grant held, `req_o` rises after such an edge and RAS falls LEAD_CYC+1 edges later.
- R10: Suppose a request arrives while MAX_BACKLOG requests are already pending and none completes on that edge. Then, on that edge:
  - `overrun_o` is set and stays set until reset;
  - `init_done_o` clears;
  - the backlog clears;
  - WAKE_CNT wake-up cycles are required again.
- R11: `req_o` is 1 whenever a strobe is low and whenever wake-up or backlog work is pending outside the pause; it is 0 when the block is idle with no work.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| grant_i | input | 1 | Bus granted by the access sequencer |
| mode_ro_i | input | 1 | 1 = RAS-only refresh, 0 = CAS-before-RAS |
| req_o | output | 1 | Bus request to the access sequencer |
| ras_n_o | output | 1 | Row strobe override, active low |
| cas_n_o | output | 1 | Column strobe override, active low |
| we_n_o | output | 1 | Write enable, held high |
| oe_n_o | output | 1 | Output enable, held high |
| addr_o | output | ROW_W | Row address for RAS-only cycles, otherwise 0 |
| init_done_o | output | 1 | Initialisation complete; normal accesses allowed |
| overrun_o | output | 1 | Sticky refresh backlog overrun flag |

## Verification
Every result is registered, so each one appears on a known edge:
- The request rises on edge PAUSE_CYC.
- `init_done_o` rises on the RAS release of the last wake-up cycle. With the grant held, that is edge PAUSE_CYC+1+(WAKE_CNT−1)·(1+LEAD_CYC+RAS_CYC+PRE_CYC)+LEAD_CYC+RAS_CYC.
- A counted request shows on `req_o` on its own edge, and RAS falls LEAD_CYC+1 edges after it.
- An overrun shows on the edge of the fourth unserved request.

The bench computes these edge numbers in functions. It samples on the falling edge just before and just after each one. A strobe monitor measures every cycle's lead, active and precharge lengths in clocks. It also looks back LEAD_CYC+1 samples to find the grant and mode seen at the start edge.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;

  typedef enum logic [2:0] {
    ST_PAUSE,
    ST_IDLE,
    ST_LEAD,
    ST_ACTIVE,
    ST_PRE
  } ref_st_e;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dram_ref_timer.sv
module dram_ref_timer #(
  parameter int INTERVAL_CYC = 1560,
  parameter int MAX_BACKLOG  = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic done_i,
  output logic pending_o,
  output logic restart_o,
  output logic overrun_o
);

  localparam int TC_W = (INTERVAL_CYC > 1) ? $clog2(INTERVAL_CYC) : 1;
  localparam int BL_W = $clog2(MAX_BACKLOG + 1);

  logic [TC_W-1:0] tcnt;
  logic [BL_W-1:0] backlog;
  logic            tick;
  logic            ovr_q;

  assign tick      = run_i && (tcnt == TC_W'(INTERVAL_CYC - 1));
  assign restart_o = tick && !done_i && (backlog == BL_W'(MAX_BACKLOG));
  assign pending_o = (backlog != '0);
  assign overrun_o = ovr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tcnt    <= '0;
      backlog <= '0;
      ovr_q   <= 1'b0;
    end else if (!run_i) begin
      tcnt    <= '0;
      backlog <= '0;
    end else begin
      tcnt <= tick ? '0 : tcnt + TC_W'(1);
      if (restart_o) begin
        backlog <= '0;
        ovr_q   <= 1'b1;
      end else begin
        unique case ({tick, done_i})
          2'b10:   backlog <= backlog + BL_W'(1);
          2'b01:   backlog <= backlog - BL_W'(1);
          default: backlog <= backlog;
        endcase
      end
    end
  end

  p_overrun_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |=> overrun_o);

  p_backlog_cap_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    backlog <= BL_W'(MAX_BACKLOG));

endmodule

// File: rtl/dram_ref_rowctr.sv
module dram_ref_rowctr #(
  parameter int ROW_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  output logic [ROW_W-1:0] row_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    row_o <= '0;
    else if (adv_i) row_o <= row_o + ROW_W'(1);
  end

  p_row_wrap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && (row_o == '1)) |=> (row_o == '0));

endmodule

// File: rtl/dram_ref_seq.sv
module dram_ref_seq
  import dram_ref_pkg::*;
#(
  parameter int PAUSE_CYC = 20000,
  parameter int WAKE_CNT  = 8,
  parameter int LEAD_CYC  = 1,
  parameter int RAS_CYC   = 5,
  parameter int PRE_CYC   = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic grant_i,
  input  logic mode_ro_i,
  input  logic pending_i,
  input  logic restart_i,
  output logic req_o,
  output logic ras_n_o,
  output logic cas_n_o,
  output logic addr_sel_o,
  output logic adv_o,
  output logic done_o,
  output logic init_done_o
);

  localparam int MAXC = max_of(max_of(PAUSE_CYC, LEAD_CYC), max_of(RAS_CYC, PRE_CYC));
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam int WK_W  = $clog2(WAKE_CNT + 1);

  ref_st_e          st;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;
  logic [WK_W-1:0]  wake_left;
  logic             cyc_ro;
  logic             init_q;
  logic             need;
  logic             phase_end;
  logic             ras_end;

  assign need = (wake_left != '0) || pending_i;

  always_comb begin
    unique case (st)
      ST_PAUSE:  lim = CNT_W'(PAUSE_CYC - 1);
      ST_LEAD:   lim = CNT_W'(LEAD_CYC - 1);
      ST_ACTIVE: lim = CNT_W'(RAS_CYC - 1);
      ST_PRE:    lim = CNT_W'(PRE_CYC - 1);
      default:   lim = '0;
    endcase
  end

  assign phase_end = (cnt == lim);
  assign ras_end   = (st == ST_ACTIVE) && phase_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st        <= ST_PAUSE;
      cnt       <= '0;
      wake_left <= WK_W'(WAKE_CNT);
      cyc_ro    <= 1'b0;
      init_q    <= 1'b0;
    end else begin
      unique case (st)
        ST_PAUSE: begin
          if (phase_end) begin st <= ST_IDLE; cnt <= '0; end
          else cnt <= cnt + CNT_W'(1);
        end
        ST_IDLE: begin
          if (need && grant_i) begin
            st     <= ST_LEAD;
            cnt    <= '0;
            cyc_ro <= mode_ro_i;
          end
        end
        ST_LEAD: begin
          if (phase_end) begin st <= ST_ACTIVE; cnt <= '0; end
          else cnt <= cnt + CNT_W'(1);
        end
        ST_ACTIVE: begin
          if (phase_end) begin st <= ST_PRE; cnt <= '0; end
          else cnt <= cnt + CNT_W'(1);
        end
        ST_PRE: begin
          if (phase_end) begin st <= ST_IDLE; cnt <= '0; end
          else cnt <= cnt + CNT_W'(1);
        end
        default: st <= ST_PAUSE;
      endcase
      // overrun restart wins over a wake-up count on the same edge
      if (restart_i) begin
        wake_left <= WK_W'(WAKE_CNT);
        init_q    <= 1'b0;
      end else if (ras_end && (wake_left != '0)) begin
        wake_left <= wake_left - WK_W'(1);
        if (wake_left == WK_W'(1)) init_q <= 1'b1;
      end
    end
  end

  assign req_o       = ((st == ST_IDLE) && need) || (st == ST_LEAD) ||
                       (st == ST_ACTIVE) || (st == ST_PRE);
  assign ras_n_o     = (st != ST_ACTIVE);
  assign cas_n_o     = !(!cyc_ro && ((st == ST_LEAD) || (st == ST_ACTIVE)));
  assign addr_sel_o  = cyc_ro && ((st == ST_LEAD) || (st == ST_ACTIVE));
  assign adv_o       = ras_end && cyc_ro;
  assign done_o      = ras_end && (wake_left == '0);
  assign init_done_o = init_q;

  p_pause_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_PAUSE) |-> (ras_n_o && cas_n_o && !req_o));

  p_start_granted_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(st) == ST_IDLE) && (st == ST_LEAD)) |-> $past(grant_i));

  p_cbr_cas_first_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ras_n_o) && !cas_n_o) |-> !$past(cas_n_o));

  p_init_on_ras_rise_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(init_done_o) |-> $rose(ras_n_o));

endmodule

// File: rtl/dram_refresh_mgr.sv
module dram_refresh_mgr #(
  parameter int PAUSE_CYC    = 20000,
  parameter int INTERVAL_CYC = 1560,
  parameter int WAKE_CNT     = 8,
  parameter int MAX_BACKLOG  = 8,
  parameter int ROW_W        = 11,
  parameter int LEAD_CYC     = 1,
  parameter int RAS_CYC      = 5,
  parameter int PRE_CYC      = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             grant_i,
  input  logic             mode_ro_i,
  output logic             req_o,
  output logic             ras_n_o,
  output logic             cas_n_o,
  output logic             we_n_o,
  output logic             oe_n_o,
  output logic [ROW_W-1:0] addr_o,
  output logic             init_done_o,
  output logic             overrun_o
);

  logic             pending;
  logic             restart;
  logic             done;
  logic             adv;
  logic             addr_sel;
  logic [ROW_W-1:0] row;

  dram_ref_seq #(
    .PAUSE_CYC (PAUSE_CYC),
    .WAKE_CNT  (WAKE_CNT),
    .LEAD_CYC  (LEAD_CYC),
    .RAS_CYC   (RAS_CYC),
    .PRE_CYC   (PRE_CYC)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .grant_i     (grant_i),
    .mode_ro_i   (mode_ro_i),
    .pending_i   (pending),
    .restart_i   (restart),
    .req_o       (req_o),
    .ras_n_o     (ras_n_o),
    .cas_n_o     (cas_n_o),
    .addr_sel_o  (addr_sel),
    .adv_o       (adv),
    .done_o      (done),
    .init_done_o (init_done_o)
  );

  dram_ref_timer #(
    .INTERVAL_CYC (INTERVAL_CYC),
    .MAX_BACKLOG  (MAX_BACKLOG)
  ) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (init_done_o),
    .done_i    (done),
    .pending_o (pending),
    .restart_o (restart),
    .overrun_o (overrun_o)
  );

  dram_ref_rowctr #(
    .ROW_W (ROW_W)
  ) u_row (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (adv),
    .row_o  (row)
  );

  assign addr_o = addr_sel ? row : '0;
  assign we_n_o = 1'b1;
  assign oe_n_o = 1'b1;

  p_req_in_cycle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ras_n_o || !cas_n_o) |-> req_o);

  p_ovr_drops_init_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overrun_o) |-> !init_done_o);

endmodule

// File: tb/dram_refresh_mgr_tb.sv
module dram_refresh_mgr_tb;

  localparam int P   = 50;
  localparam int I   = 16;
  localparam int W   = 8;
  localparam int MB  = 3;
  localparam int RW  = 11;
  localparam int L   = 1;
  localparam int R   = 4;
  localparam int PR  = 3;
  localparam int NROWS = 1 << RW;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          grant_i = 1'b0;
  logic          mode_ro_i = 1'b0;
  logic          req_o, ras_n_o, cas_n_o, we_n_o, oe_n_o, init_done_o, overrun_o;
  logic [RW-1:0] addr_o;

  int n_chk = 0;
  int n_bad = 0;
  int ecnt  = 0;
  bit fin   = 0;

  always #5 clk = ~clk;

  dram_refresh_mgr #(
    .PAUSE_CYC (P), .INTERVAL_CYC (I), .WAKE_CNT (W), .MAX_BACKLOG (MB),
    .ROW_W (RW), .LEAD_CYC (L), .RAS_CYC (R), .PRE_CYC (PR)
  ) u_dut (
    .clk_i (clk), .rst_ni (rst_ni), .grant_i (grant_i), .mode_ro_i (mode_ro_i),
    .req_o (req_o), .ras_n_o (ras_n_o), .cas_n_o (cas_n_o), .we_n_o (we_n_o),
    .oe_n_o (oe_n_o), .addr_o (addr_o), .init_done_o (init_done_o),
    .overrun_o (overrun_o)
  );

  always @(posedge clk or negedge rst_ni)
    if (!rst_ni) ecnt <= 0; else ecnt <= ecnt + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // edge on which init_done rises when grant is held from cycle start edge s
  function automatic int init_edge(input int s);
    return s + (W - 1) * (1 + L + R + PR) + L + R;
  endfunction

  task automatic at_neg(input int n);
    while (ecnt != n) @(negedge clk);
  endtask

  task automatic set_in(input bit g, input bit m);
    @(posedge clk); #2;
    grant_i = g;
    mode_ro_i = m;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    chk(ras_n_o && cas_n_o, "R1 strobes high in reset", {ras_n_o, cas_n_o}, 3);
    chk(!req_o && !init_done_o && !overrun_o, "R1 outputs low in reset",
        {req_o, init_done_o, overrun_o}, 0);
    rst_ni = 1'b1;
  endtask

  // strobe monitor
  logic [7:0] gh, mh;
  logic       p_ras, p_cas, p_init, p_ovr, cyc_ro;
  logic [RW-1:0] p_addr;
  int cas_lo, ras_lo, hi_n, exp_row, wake_n, ras_falls;
  bit wrap_seen;

  always @(negedge clk) begin
    if (!rst_ni) begin
      gh = '0; mh = '0; p_ras = 1; p_cas = 1; p_init = 0; p_ovr = 0; cyc_ro = 0;
      p_addr = '0; cas_lo = 0; ras_lo = 0; hi_n = 1000; exp_row = 0; wake_n = 0;
      ras_falls = 0;
    end else begin
      chk(we_n_o && oe_n_o, "R6 we/oe high", {we_n_o, oe_n_o}, 3);
      if (p_ras && p_cas && !(ras_n_o && cas_n_o))
        chk(hi_n >= PR, "R3 R4 precharge length", hi_n, PR);
      if (p_ras && !ras_n_o) begin
        ras_falls++;
        cyc_ro = cas_n_o;
        chk(gh[L] == 1'b1, "R7 start needs grant", gh[L], 1);
        chk(cyc_ro == mh[L], "R8 form from start-edge mode", cyc_ro, mh[L]);
        if (!cyc_ro)
          chk(cas_lo == L, "R3 CAS lead", cas_lo, L);
        else
          chk(p_addr == RW'(exp_row), "R4 row setup before RAS", p_addr, exp_row);
      end
      if (!ras_n_o) begin
        if (cyc_ro) chk(addr_o == RW'(exp_row), "R4 R5 row during RAS", addr_o, exp_row);
        else        chk(addr_o == '0, "R3 addr zero in CBR", addr_o, 0);
      end
      if (!p_ras && ras_n_o) begin
        chk(ras_lo == R, "R3 R4 RAS active length", ras_lo, R);
        chk(cas_n_o, "R3 CAS released with RAS", cas_n_o, 1);
        if (cyc_ro) begin
          if (exp_row == NROWS - 1) wrap_seen = 1;
          exp_row = (exp_row + 1) % NROWS;
        end
        wake_n++;
      end
      if (!p_ovr && overrun_o) begin
        chk(!init_done_o, "R10 init drops on overrun", init_done_o, 0);
        wake_n = 0;
      end
      if (!p_init && init_done_o)
        chk(wake_n == W, "R2 wake cycle count", wake_n, W);
      cas_lo = cas_n_o ? 0 : cas_lo + 1;
      ras_lo = ras_n_o ? 0 : ras_lo + 1;
      hi_n   = (ras_n_o && cas_n_o) ? hi_n + 1 : 0;
      p_ras = ras_n_o; p_cas = cas_n_o; p_init = init_done_o; p_ovr = overrun_o;
      p_addr = addr_o;
      gh = {gh[6:0], grant_i};
      mh = {mh[6:0], mode_ro_i};
    end
  end

  task automatic finish_run();
    if (!fin) begin
      fin = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (120000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired act=0 exp=1");
    finish_run();
  end

  initial begin
    int d, d2, s, rf;
    void'($urandom(32'h5eed_0042));

    // A: pause, wake-up, periodic request (CBR)
    grant_i = 1; mode_ro_i = 0;
    do_reset();
    at_neg(P - 1);
    chk(!req_o, "R1 no request during pause", req_o, 0);
    at_neg(P);
    chk(req_o, "R1 R11 request after pause", req_o, 1);
    d = init_edge(P + 1);
    at_neg(d - 1);
    chk(!init_done_o, "R2 init not yet", init_done_o, 0);
    at_neg(d);
    chk(init_done_o, "R2 init after wake burst", init_done_o, 1);
    at_neg(d + I - 1);
    chk(!req_o, "R11 idle without work", req_o, 0);
    at_neg(d + I);
    chk(req_o, "R9 request at interval", req_o, 1);
    at_neg(d + I + L);
    chk(ras_n_o, "R9 RAS not yet low", ras_n_o, 1);
    at_neg(d + I + L + 1);
    chk(!ras_n_o, "R9 RAS falls after lead", ras_n_o, 0);

    // B: withhold grant until overrun, then wake-up again
    grant_i = 1; mode_ro_i = 0;
    do_reset();
    d = init_edge(P + 1);
    at_neg(d);
    set_in(0, 0);
    rf = ras_falls;
    at_neg(d + (MB + 1) * I - 1);
    chk(!overrun_o && init_done_o, "R10 no overrun before limit",
        {overrun_o, init_done_o}, 1);
    chk(rf == ras_falls, "R7 no cycle without grant", ras_falls, rf);
    at_neg(d + (MB + 1) * I);
    chk(overrun_o, "R10 overrun set", overrun_o, 1);
    chk(!init_done_o, "R10 init cleared", init_done_o, 0);
    set_in(1, 0);
    s = d + (MB + 1) * I + 2;
    d2 = init_edge(s);
    at_neg(d2 - 1);
    chk(!init_done_o, "R10 wake repeated, not done", init_done_o, 0);
    at_neg(d2);
    chk(init_done_o && overrun_o, "R10 wake repeated, overrun sticky",
        {init_done_o, overrun_o}, 3);

    // C: random grant and mode
    for (int k = 0; k < 4000; k++)
      set_in(($urandom % 4) != 0, $urandom % 2);

    // D: RAS-only through the row wrap
    grant_i = 1; mode_ro_i = 1;
    wrap_seen = 0;
    do_reset();
    while (!wrap_seen) @(negedge clk);
    repeat (3 * I) @(negedge clk);
    chk(wrap_seen && exp_row >= 1, "R5 row wrapped to 0 and continued", exp_row, 1);
    finish_run();
  end

endmodule